// File: doc/BRIEF.md
# Single-Entry Atomic Reservation Monitor

This block tracks one load-reserved / store-conditional reservation for one processor. An atomic load records the byte range it reads. A later atomic store asks the monitor whether that range is still reserved. One cycle after the store, the monitor returns a pass or fail result. The core loads this result into its equals flag and uses it as the write enable for the store, so software can loop on a conditional jump until a store passes.

A second port observes the successful atomic stores of other agents. If such a store touches any byte of the reserved range, the monitor cancels the reservation. The data path to memory is outside this block.

The controller has two named states:
- `RSV_EMPTY`: no reservation is held.
- `RSV_HELD`: one reservation is held.

The transitions are:
- **reserve**: an atomic load moves `RSV_EMPTY` to `RSV_HELD`.
- **re-reserve**: an atomic load in `RSV_HELD` stays in `RSV_HELD` and overwrites the recorded range.
- **consume**: a local atomic store moves `RSV_HELD` to `RSV_EMPTY`.
- **cancel**: an overlapping snoop moves `RSV_HELD` to `RSV_EMPTY`.
- **keep**: with none of the above, the state is unchanged.

Top module: `atomic_rsv_monitor`

## Requirements
- R1: After reset no reservation is held and `sc_done`/`sc_ok` are low, so a store issued before any atomic load returns `sc_ok`=0.
- R2: A request with `req_op`=0 (atomic load) records `req_addr` and the size code `req_size` as the reservation and enters `RSV_HELD`. The size code gives the byte count as 1 << code: 0 means 1 byte, 1 means 2, 2 means 4 and 3 means 8.
- R3: Only one reservation exists at a time. A new atomic load replaces the old range, so a snoop that hits only the old range no longer cancels anything.
- R4: A request with `req_op`=1 (atomic store) raises `sc_done` for exactly one cycle, in the cycle after the request. `sc_ok` is 1 with it when the reservation was still valid. The store's own address is not compared.
- R5: An atomic store consumes the reservation whether it passes or fails, so a second store with no new load fails.
- R6: A snoop (`snp_valid`=1) whose range [snp_addr, snp_addr + 2^snp_size) shares at least one byte with the reserved range cancels the reservation.
- R7: A snoop whose range only touches the reserved range edge to edge, or lies elsewhere, has no effect.
- R8: If an overlapping snoop and a local atomic store arrive in the same cycle, the store fails.
- R9: If an atomic load and an overlapping snoop arrive in the same cycle, the load wins and the new reservation is held.
- R10: Ranges are compared without wrap-around at the top of the address space. A range ending at the last address does not overlap address 0.
- R11: `sc_done` and `sc_ok` stay low in every cycle that does not follow an atomic store, including cycles with loads or snoops only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Local atomic request present |
| req_op | input | 1 | 0 = atomic load, 1 = atomic store |
| req_addr | input | ADDR_W (32) | Byte address of the local request |
| req_size | input | 2 | Size code of the local request, bytes = 1 << code |
| snp_valid | input | 1 | Another agent completed a successful atomic store |
| snp_addr | input | ADDR_W (32) | Byte address of that store |
| snp_size | input | 2 | Size code of that store |
| sc_done | output | 1 | Store result strobe, one cycle after a local atomic store |
| sc_ok | output | 1 | Store passed: value for the equals flag and write enable |

## Verification
On every cycle, the assertions check the state rules of the controller:
- a load always leads to `RSV_HELD`;
- a store always leads to `RSV_EMPTY`;
- an overlapping snoop cancels a held reservation unless a load arrives with it;
- a pass never appears without the result strobe, or after a store made with no reservation or in a race with a snoop.

Only the bench scenarios can show the exact geometry of the byte-range comparison. These cover edge-adjacent ranges, ranges near the top of the address space, and replacement by a second load. A reference model checks the value of each result during random mixes of loads, stores and snoops in a narrow address window.

// File: rtl/rsv_pkg.sv
`timescale 1ns/1ps
package rsv_pkg;

    // Controller states
    typedef enum logic {
        RSV_EMPTY = 1'b0,
        RSV_HELD  = 1'b1
    } rsv_state_e;

    // Local request kinds on req_op
    typedef enum logic {
        OP_LOAD_RSV  = 1'b0,
        OP_STORE_CND = 1'b1
    } rsv_op_e;

endpackage

// File: rtl/rsv_overlap.sv
`timescale 1ns/1ps
// Byte-range intersection test. Range ends are computed one bit wider
// than the address so a range that reaches the top does not wrap to 0.
module rsv_overlap #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [SIZE_W-1:0] a_size,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [SIZE_W-1:0] b_size,
    output logic              hit
);
    localparam int EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_lo = {1'b0, a_addr};
        b_lo = {1'b0, b_addr};
        a_hi = a_lo + (EXT_W'(1) << a_size);
        b_hi = b_lo + (EXT_W'(1) << b_size);
        hit  = (a_lo < b_hi) && (b_lo < a_hi);
    end

endmodule

// File: rtl/rsv_track.sv
`timescale 1ns/1ps
// Reservation controller: state register, reserved range and result outputs.
module rsv_track
    import rsv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_go,
    input  logic              st_go,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [SIZE_W-1:0] ld_size,
    input  logic              snoop_hit,
    output logic [ADDR_W-1:0] rsv_addr,
    output logic [SIZE_W-1:0] rsv_size,
    output logic              sc_done,
    output logic              sc_ok
);
    rsv_state_e state, state_nx;

    // Transition logic
    always_comb begin
        state_nx = state;
        unique case (state)
            RSV_EMPTY: begin
                if (ld_go) state_nx = RSV_HELD;          // reserve
            end
            RSV_HELD: begin
                if (ld_go)          state_nx = RSV_HELD;  // re-reserve
                else if (st_go)     state_nx = RSV_EMPTY; // consume
                else if (snoop_hit) state_nx = RSV_EMPTY; // cancel
            end
            default: state_nx = RSV_EMPTY;
        endcase
    end

    // State register and recorded range
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= RSV_EMPTY;
            rsv_addr <= '0;
            rsv_size <= '0;
        end else begin
            state <= state_nx;
            if (ld_go) begin
                rsv_addr <= ld_addr;
                rsv_size <= ld_size;
            end
        end
    end

    // Result outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sc_done <= 1'b0;
            sc_ok   <= 1'b0;
        end else begin
            sc_done <= st_go;
            sc_ok   <= st_go && (state == RSV_HELD) && !snoop_hit;
        end
    end

    // R4
    ok_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_ok |-> sc_done);

    // R11
    done_only_after_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_go |=> !sc_done);

    // R2
    load_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_go |=> (state == RSV_HELD));

    // R5
    store_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_go && !ld_go) |=> (state == RSV_EMPTY));

    // R6
    snoop_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RSV_HELD && snoop_hit && !ld_go) |=> (state == RSV_EMPTY));

    // R8
    race_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_go && snoop_hit) |=> !sc_ok);

    // R1
    empty_store_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_go && state == RSV_EMPTY) |=> !sc_ok);

endmodule

// File: rtl/atomic_rsv_monitor.sv
`timescale 1ns/1ps
module atomic_rsv_monitor
    import rsv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic              snp_valid,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [SIZE_W-1:0] snp_size,
    output logic              sc_done,
    output logic              sc_ok
);
    logic              ld_go, st_go, range_hit;
    logic [ADDR_W-1:0] rsv_addr;
    logic [SIZE_W-1:0] rsv_size;

    assign ld_go = req_valid && (rsv_op_e'(req_op) == OP_LOAD_RSV);
    assign st_go = req_valid && (rsv_op_e'(req_op) == OP_STORE_CND);

    rsv_overlap #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_overlap (
        .a_addr (rsv_addr),
        .a_size (rsv_size),
        .b_addr (snp_addr),
        .b_size (snp_size),
        .hit    (range_hit)
    );

    rsv_track #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_go     (ld_go),
        .st_go     (st_go),
        .ld_addr   (req_addr),
        .ld_size   (req_size),
        .snoop_hit (snp_valid && range_hit),
        .rsv_addr  (rsv_addr),
        .rsv_size  (rsv_size),
        .sc_done   (sc_done),
        .sc_ok     (sc_ok)
    );

endmodule

// File: tb/tb_atomic_rsv_monitor.sv
`timescale 1ns/1ps
module tb_atomic_rsv_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_op = 1'b0, snp_valid = 1'b0;
    logic [31:0] req_addr = '0, snp_addr = '0;
    logic [1:0]  req_size = '0, snp_size = '0;
    logic        sc_done, sc_ok;

    int checks = 0, errors = 0;
    bit finished = 0;

    // reference model state
    bit          m_held = 0;
    logic [31:0] m_addr = '0;
    logic [1:0]  m_size = '0;

    always #2 clk = ~clk;

    atomic_rsv_monitor dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_size(req_size), .snp_valid(snp_valid),
        .snp_addr(snp_addr), .snp_size(snp_size), .sc_done(sc_done), .sc_ok(sc_ok)
    );

    function automatic bit ranges_meet(logic [31:0] a, logic [1:0] sa,
                                       logic [31:0] b, logic [1:0] sb);
        longint unsigned alo = {32'b0, a};
        longint unsigned blo = {32'b0, b};
        return (alo < blo + (64'd1 << sb)) && (blo < alo + (64'd1 << sa));
    endfunction

    task automatic check(string tag, logic got, logic exp, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", tag, what, got, exp);
        end
    endtask

    // One cycle: kind 0 idle, 1 load, 2 store. Drive at negedge, check after posedge.
    task automatic step(int kind, logic [31:0] a, logic [1:0] s,
                        bit sv, logic [31:0] sa, logic [1:0] ss, string tag);
        bit exp_done, exp_ok, hit;
        req_valid = (kind != 0);
        req_op    = (kind == 2);
        req_addr  = a;  req_size = s;
        snp_valid = sv; snp_addr = sa; snp_size = ss;
        hit      = sv && ranges_meet(m_addr, m_size, sa, ss);
        exp_done = (kind == 2);
        exp_ok   = (kind == 2) && m_held && !hit;
        if (kind == 1) begin
            m_held = 1; m_addr = a; m_size = s;
        end else if (kind == 2) begin
            m_held = 0;
        end else if (hit) begin
            m_held = 0;
        end
        @(posedge clk); #1;
        check(tag, sc_done, exp_done, "sc_done");
        check(tag, sc_ok, exp_ok, "sc_ok");
        @(negedge clk);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1", sc_done, 1'b0, "sc_done in reset");
        check("R1", sc_ok, 1'b0, "sc_ok in reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R1: store with no reservation
        step(2, 32'h100, 2'd2, 0, 0, 0, "R1");
        // R2 R4: load then store passes
        step(1, 32'h100, 2'd2, 0, 0, 0, "R2");
        step(0, 0, 0, 0, 0, 0, "R11");
        step(2, 32'h500, 2'd0, 0, 0, 0, "R4");
        // R5: consumed
        step(2, 32'h100, 2'd2, 0, 0, 0, "R5");
        // R6: overlapping snoop on last byte
        step(1, 32'h100, 2'd2, 0, 0, 0, "R6");
        step(0, 0, 0, 1, 32'h103, 2'd0, "R6");
        step(2, 32'h100, 2'd2, 0, 0, 0, "R6");
        // R6: wide snoop covering the range
        step(1, 32'h102, 2'd0, 0, 0, 0, "R6");
        step(0, 0, 0, 1, 32'h100, 2'd3, "R6");
        step(2, 32'h102, 2'd0, 0, 0, 0, "R6");
        // R7: adjacent above and below
        step(1, 32'h100, 2'd2, 0, 0, 0, "R7");
        step(0, 0, 0, 1, 32'h104, 2'd2, "R7");
        step(0, 0, 0, 1, 32'h0FC, 2'd2, "R7");
        step(2, 32'h100, 2'd2, 0, 0, 0, "R7");
        // R3: replacement
        step(1, 32'h100, 2'd3, 0, 0, 0, "R3");
        step(1, 32'h200, 2'd0, 0, 0, 0, "R3");
        step(0, 0, 0, 1, 32'h100, 2'd3, "R3");
        step(2, 32'h200, 2'd0, 0, 0, 0, "R3");
        // R8: race store vs snoop
        step(1, 32'h300, 2'd1, 0, 0, 0, "R8");
        step(2, 32'h300, 2'd1, 1, 32'h301, 2'd0, "R8");
        step(2, 32'h300, 2'd1, 0, 0, 0, "R8");
        // R9: load with overlapping snoop
        step(1, 32'h400, 2'd2, 1, 32'h400, 2'd2, "R9");
        step(2, 32'h400, 2'd2, 0, 0, 0, "R9");
        // R10: top of address space
        step(1, 32'hFFFF_FFFC, 2'd2, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 32'h0, 2'd3, "R10");
        step(2, 32'hFFFF_FFFC, 2'd2, 0, 0, 0, "R10");
        step(1, 32'hFFFF_FFF8, 2'd3, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 32'hFFFF_FFFF, 2'd0, "R10");
        step(2, 32'hFFFF_FFF8, 2'd3, 0, 0, 0, "R10");
        // R11: snoops and loads alone never strobe
        step(0, 0, 0, 1, 32'h10, 2'd1, "R11");
        step(1, 32'h10, 2'd1, 0, 0, 0, "R11");
        // random mix in a narrow window, plus wrap-region addresses
        for (int i = 0; i < 3000; i++) begin
            int kind = int'($urandom_range(0, 2));
            logic [31:0] ra = ($urandom_range(0, 9) == 0) ?
                              (32'hFFFF_FFF0 + 32'($urandom_range(0, 15))) :
                              (32'h100 + 32'($urandom_range(0, 31)));
            logic [31:0] sa = ($urandom_range(0, 9) == 0) ?
                              32'($urandom_range(0, 7)) :
                              (32'h100 + 32'($urandom_range(0, 31)));
            step(kind, ra, 2'($urandom_range(0, 3)), $urandom_range(0, 2) == 0,
                 sa, 2'($urandom_range(0, 3)), "R4_random");
        end
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule